// File: doc/BRIEF.md
# Chunked Hamming Parity Generator for a NAND Byte Stream

This block sits beside the byte path between a host and a NAND flash device and builds a single-error-correcting Hamming parity word over every 256 data bytes that cross the flash bus. Each byte that really moves as data is folded into running line and column parity accumulators. Command and address cycles are skipped, as are cycles with the enable control low. When the 256th accepted byte arrives, the finished word is latched into a readout register and a one-cycle valid strobe is raised. The accumulator then starts from zero for the next chunk with no dead cycle. A large page therefore yields eight words and a small page yields two.

The readout word is also presented in the 3-byte spare-area form: shifted left by two, inverted and truncated to 24 bits. A slot selector returns those bytes most significant first, which is the order a writer stores them in the spare area. A clear control empties the accumulator and the byte counter. A second enable lets the latched word raise a fetch request toward a DMA engine. With this code, one flipped bit in a 256-byte chunk can be located from the difference between the stored word and a recomputed word.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After synchronous reset, `ecc_word` is 0, `ecc_vld` and `ecc_dreq` are 0, `spare_word` is 24'hFFFFFF, and the byte counter of the chunk is at zero.
- R2: A byte is accepted only in a cycle where `ecc_en`=1, `bus_stb`=1 and `bus_cyc`=2'b11 (data), and `clr`=0. The other `bus_cyc` codes are 2'b00 idle, 2'b01 command and 2'b10 address.
- R3: The line parity occupies `ecc_word[21:6]`. For byte-index bit k (0..7), bit 6+2k is the XOR of all bits of the accepted bytes whose index in the chunk has bit k = 0, and bit 7+2k is the same XOR over bytes whose index has bit k = 1.
- R4: The column parity occupies `ecc_word[5:0]`. For bit-position bit j (0..2), bit 2j is the XOR over all accepted bytes of the data bits whose position has bit j = 0, and bit 2j+1 covers the positions with bit j = 1.
- R5: On the clock edge that accepts the 256th byte of a chunk, the finished word is loaded into `ecc_word`, and `ecc_vld` is 1 for exactly the following cycle. The next chunk's parity starts from zero.
- R6: `clr`=1 empties the accumulator and the byte counter, and it drops a byte offered in the same cycle. `ecc_word` keeps its last value.
- R7: `ecc_dreq` is 1 together with `ecc_vld` only if `dma_en` was 1 on the capturing edge. Otherwise it stays 0.
- R8: `spare_word` equals the bitwise NOT of `{ecc_word, 2'b00}`, truncated to 24 bits.
- R9: `spare_byte` returns `spare_word[23:16]` for `pk_sel`=0, `[15:8]` for 1, `[7:0]` for 2, and 8'h00 for 3.
- R10: Bytes that are not accepted (command, address, strobe low, or enable low) change neither the parity nor the count. A chunk with such bytes mixed in gives the same word, with the same 256-byte timing, as one without them.
- R11: Flipping a single bit of one byte in a chunk changes exactly one bit of each of the 11 parity pairs. The odd bits of the changed pairs spell out the byte index (line bits) and the bit position (column bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Parity accumulation enable |
| dma_en | input | 1 | Allows a latched word to raise a fetch request |
| clr | input | 1 | Clears accumulator and byte counter |
| bus_stb | input | 1 | A byte moves on the flash bus this cycle |
| bus_cyc | input | 2 | Cycle kind: 00 idle, 01 command, 10 address, 11 data |
| bus_data | input | 8 | Byte on the flash bus |
| pk_sel | input | 2 | Spare byte slot, 0 = most significant |
| ecc_word | output | 22 | Latched raw parity word of the last chunk |
| ecc_vld | output | 1 | One-cycle strobe after a word is latched |
| ecc_dreq | output | 1 | Fetch request, with ecc_vld when enabled |
| spare_word | output | 24 | Spare-area form of ecc_word |
| spare_byte | output | 8 | Selected spare byte |

## Verification
The embedded assertions check the properties that hold on every cycle. The counter and the accumulator return to zero after a clear and after the closing byte of a chunk. Both hold their values in cycles with no accepted byte. The valid strobe lasts a single cycle, and the fetch request never appears without it. Only the directed scenarios can show the parity values themselves: the line and column equations over whole chunks, the immunity to command, address and disabled bytes, the spare-area packing and byte order, and the single-bit-error signature. Each is compared against a word model computed independently in the bench.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'b00,
        CYC_CMD  = 2'b01,
        CYC_ADDR = 2'b10,
        CYC_DATA = 2'b11
    } bus_cyc_e;

    localparam int unsigned DEF_DATA_W   = 8;
    localparam int unsigned DEF_CHUNK    = 256;
    localparam int unsigned SPARE_BYTES  = 3;
    localparam int unsigned SPARE_SHIFT  = 2;

    typedef struct packed {
        logic accept;
        logic last;
    } step_t;

    function automatic int unsigned word_width(input int unsigned data_w, input int unsigned chunk);
        return 2 * $clog2(chunk) + 2 * $clog2(data_w);
    endfunction

endpackage

// File: rtl/ecc_chunk_ctr.sv
module ecc_chunk_ctr #(
    parameter int unsigned CHUNK = 256,
    localparam int unsigned IDX_W = $clog2(CHUNK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              accept,
    output logic [IDX_W-1:0]  idx,
    output logic              last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHUNK - 1);

    assign last = accept && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (accept) begin
            idx <= last ? '0 : idx + 1'b1;
        end
    end

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (idx == '0)); // R6

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!accept && !clr) |=> $stable(idx)); // R2

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (last && !clr) |=> (idx == '0)); // R5

endmodule

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned IDX_W  = 8,
    localparam int unsigned COL_W  = $clog2(DATA_W),
    localparam int unsigned COL_B  = 2 * COL_W,
    localparam int unsigned LINE_B = 2 * IDX_W,
    localparam int unsigned WORD_W = LINE_B + COL_B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              accept,
    input  logic              last,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] data,
    output logic [WORD_W-1:0] acc_upd
);
    logic [WORD_W-1:0] acc;
    logic [LINE_B-1:0] line_c;
    logic [COL_B-1:0]  col_c;
    logic              byte_par;

    assign byte_par = ^data;

    // line parity: each byte index bit selects the even or odd member of a pair
    for (genvar k = 0; k < IDX_W; k++) begin : g_line
        assign line_c[2*k]   = byte_par & ~idx[k];
        assign line_c[2*k+1] = byte_par &  idx[k];
    end

    // column parity: each bit-position bit splits the byte into two halves
    always_comb begin
        col_c = '0;
        for (int j = 0; j < COL_W; j++) begin
            for (int b = 0; b < DATA_W; b++) begin
                if (b[j]) col_c[2*j+1] = col_c[2*j+1] ^ data[b];
                else      col_c[2*j]   = col_c[2*j]   ^ data[b];
            end
        end
    end

    assign acc_upd = acc ^ {line_c, col_c};

    always_ff @(posedge clk) begin
        if (rst || clr || (accept && last)) begin
            acc <= '0;
        end else if (accept) begin
            acc <= acc_upd;
        end
    end

    AST_ACC_RESTART: assert property (@(posedge clk) disable iff (rst)
        (accept && last) |=> (acc == '0)); // R5

    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!accept && !clr) |=> $stable(acc)); // R10

endmodule

// File: rtl/ecc_capture.sv
module ecc_capture #(
    parameter int unsigned WORD_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              dma_en,
    input  logic [WORD_W-1:0] acc_upd,
    output logic [WORD_W-1:0] word,
    output logic              vld,
    output logic              dreq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            vld  <= 1'b0;
            dreq <= 1'b0;
        end else begin
            vld  <= capture;
            dreq <= capture && dma_en;
            if (capture) word <= acc_upd;
        end
    end

    AST_DREQ_WITH_VLD: assert property (@(posedge clk) disable iff (rst)
        dreq |-> vld); // R7

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld); // R5

    AST_WORD_KEPT: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(word)); // R6

endmodule

// File: rtl/ecc_packer.sv
module ecc_packer #(
    parameter int unsigned WORD_W  = 22,
    parameter int unsigned SHIFT   = 2,
    parameter int unsigned N_BYTES = 3,
    localparam int unsigned PACK_W = 8 * N_BYTES,
    localparam int unsigned SEL_W  = $clog2(N_BYTES + 1)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output logic [PACK_W-1:0] packed_word,
    output logic [7:0]        byte_out
);
    logic [WORD_W+SHIFT-1:0] shifted;
    logic [7:0]              slot [N_BYTES];

    assign shifted     = {word, {SHIFT{1'b0}}};
    assign packed_word = ~PACK_W'(shifted);

    // slot 0 holds the most significant byte
    for (genvar s = 0; s < N_BYTES; s++) begin : g_slot
        assign slot[s] = packed_word[PACK_W-1-8*s -: 8];
    end

    always_comb begin
        byte_out = 8'h00;
        for (int s = 0; s < N_BYTES; s++) begin
            if (sel == SEL_W'(s)) byte_out = slot[s];
        end
    end

endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
    import nand_ecc_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned CHUNK  = DEF_CHUNK,
    localparam int unsigned IDX_W  = $clog2(CHUNK),
    localparam int unsigned WORD_W = word_width(DATA_W, CHUNK),
    localparam int unsigned PACK_W = 8 * SPARE_BYTES,
    localparam int unsigned SEL_W  = $clog2(SPARE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ecc_en,
    input  logic              dma_en,
    input  logic              clr,
    input  logic              bus_stb,
    input  logic [1:0]        bus_cyc,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [SEL_W-1:0]  pk_sel,
    output logic [WORD_W-1:0] ecc_word,
    output logic              ecc_vld,
    output logic              ecc_dreq,
    output logic [PACK_W-1:0] spare_word,
    output logic [7:0]        spare_byte
);
    bus_cyc_e          cyc;
    step_t             step;
    logic [IDX_W-1:0]  idx;
    logic              last;
    logic [WORD_W-1:0] acc_upd;

    assign cyc         = bus_cyc_e'(bus_cyc);
    assign step.accept = ecc_en && bus_stb && (cyc == CYC_DATA) && !clr;
    assign step.last   = last;

    ecc_chunk_ctr #(.CHUNK(CHUNK)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .accept (step.accept),
        .idx    (idx),
        .last   (last)
    );

    ecc_parity_acc #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .accept  (step.accept),
        .last    (step.last),
        .idx     (idx),
        .data    (bus_data),
        .acc_upd (acc_upd)
    );

    ecc_capture #(.WORD_W(WORD_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .capture (step.last),
        .dma_en  (dma_en),
        .acc_upd (acc_upd),
        .word    (ecc_word),
        .vld     (ecc_vld),
        .dreq    (ecc_dreq)
    );

    ecc_packer #(.WORD_W(WORD_W), .SHIFT(SPARE_SHIFT), .N_BYTES(SPARE_BYTES)) u_pack (
        .word        (ecc_word),
        .sel         (pk_sel),
        .packed_word (spare_word),
        .byte_out    (spare_byte)
    );

    AST_NO_CAPTURE_ON_NONDATA: assert property (@(posedge clk) disable iff (rst)
        (cyc != CYC_DATA || !ecc_en || !bus_stb) |=> !ecc_vld); // R2

endmodule

// File: tb/sim_nand_hamming_ecc.sv
module sim_nand_hamming_ecc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, ecc_en, dma_en, clr, bus_stb;
    logic [1:0]  bus_cyc, pk_sel;
    logic [7:0]  bus_data;
    logic [21:0] ecc_word;
    logic        ecc_vld, ecc_dreq;
    logic [23:0] spare_word;
    logic [7:0]  spare_byte;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] mem [256];

    nand_hamming_ecc u0 (
        .clk(clk), .rst(rst), .ecc_en(ecc_en), .dma_en(dma_en), .clr(clr),
        .bus_stb(bus_stb), .bus_cyc(bus_cyc), .bus_data(bus_data), .pk_sel(pk_sel),
        .ecc_word(ecc_word), .ecc_vld(ecc_vld), .ecc_dreq(ecc_dreq),
        .spare_word(spare_word), .spare_byte(spare_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [21:0] model();
        logic [21:0] w = '0;
        for (int i = 0; i < 256; i++) begin
            logic p = ^mem[i];
            for (int k = 0; k < 8; k++) begin
                if (i[k]) w[7+2*k] ^= p; else w[6+2*k] ^= p;
            end
            for (int b = 0; b < 8; b++) begin
                for (int j = 0; j < 3; j++) begin
                    if (b[j]) w[2*j+1] ^= mem[i][b]; else w[2*j] ^= mem[i][b];
                end
            end
        end
        return w;
    endfunction

    task automatic push(input logic [7:0] d, input logic [1:0] cyc, input logic en);
        @(negedge clk);
        bus_stb = 1'b1; bus_cyc = cyc; bus_data = d; ecc_en = en;
    endtask

    task automatic go_idle();
        @(negedge clk);
        bus_stb = 1'b0; bus_cyc = 2'b00; ecc_en = 1'b1;
    endtask

    // sends mem as one chunk and checks the latched word and strobe timing
    task automatic run_chunk(input string req, output logic [21:0] got);
        logic [21:0] exp = model();
        for (int i = 0; i < 256; i++) push(mem[i], 2'b11, 1'b1);
        go_idle();
        got = ecc_word;
        chk(ecc_vld == 1'b1, {req, " vld after 256th"}, ecc_vld, 1);
        chk(ecc_word == exp, {req, " word"}, ecc_word, exp);
        @(negedge clk);
        chk(ecc_vld == 1'b0, "R5 vld one cycle", ecc_vld, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; ecc_en = 1'b0; dma_en = 1'b0; clr = 1'b0; bus_stb = 1'b0;
        bus_cyc = 2'b00; bus_data = 8'h00; pk_sel = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ecc_word == 22'd0, "R1 word", ecc_word, 0);
        chk(ecc_vld == 1'b0 && ecc_dreq == 1'b0, "R1 strobes", {ecc_vld, ecc_dreq}, 0);
        chk(spare_word == 24'hFFFFFF, "R1 spare", spare_word, 24'hFFFFFF);
    endtask

    task automatic t_patterns();
        logic [21:0] w;
        logic [7:0]  lf = 8'h1D;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i);
        run_chunk("R3 R4 incrementing", w);
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        run_chunk("R3 R4 all ones", w);
        for (int i = 0; i < 256; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            mem[i] = lf;
        end
        run_chunk("R3 R4 lfsr", w);
        for (int i = 0; i < 256; i++) mem[i] = (i == 77) ? 8'h01 : 8'h00;
        run_chunk("R3 R4 single byte", w);
    endtask

    task automatic t_ignored();
        logic [21:0] exp;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        exp = model();
        for (int i = 0; i < 256; i++) begin
            push(8'h5A, 2'b01, 1'b1);
            push(8'hC3, 2'b10, 1'b1);
            push(8'hFF, 2'b11, 1'b0);
            @(negedge clk); bus_stb = 1'b0; bus_cyc = 2'b11; bus_data = 8'h81; ecc_en = 1'b1;
            if (i == 255) chk(ecc_vld == 1'b0, "R10 no early word", ecc_vld, 0);
            push(mem[i], 2'b11, 1'b1);
        end
        go_idle();
        chk(ecc_vld == 1'b1, "R10 vld on 256th data byte", ecc_vld, 1);
        chk(ecc_word == exp, "R2 R10 word unaffected", ecc_word, exp);
    endtask

    task automatic t_clear();
        logic [21:0] prev, w;
        prev = ecc_word;
        for (int i = 0; i < 100; i++) push(8'hA5 ^ 8'(i), 2'b11, 1'b1);
        @(negedge clk);
        clr = 1'b1; bus_stb = 1'b1; bus_cyc = 2'b11; bus_data = 8'h3C;
        @(negedge clk);
        clr = 1'b0; bus_stb = 1'b0;
        chk(ecc_word == prev, "R6 readout kept", ecc_word, prev);
        for (int i = 0; i < 256; i++) mem[i] = 8'(255 - i) ^ 8'h96;
        run_chunk("R6 after clear", w);
    endtask

    task automatic t_dma();
        logic [21:0] w;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h33);
        dma_en = 1'b1;
        for (int i = 0; i < 256; i++) push(mem[i], 2'b11, 1'b1);
        go_idle();
        chk(ecc_dreq == 1'b1, "R7 dreq with dma_en", ecc_dreq, 1);
        @(negedge clk);
        chk(ecc_dreq == 1'b0, "R7 dreq one cycle", ecc_dreq, 0);
        dma_en = 1'b0;
        for (int i = 0; i < 256; i++) push(mem[i], 2'b11, 1'b1);
        go_idle();
        w = ecc_word;
        chk(ecc_vld == 1'b1 && ecc_dreq == 1'b0, "R7 no dreq without dma_en", {ecc_vld, ecc_dreq}, 2'b10);
        @(negedge clk);
    endtask

    task automatic t_pack();
        logic [23:0] exp = ~{ecc_word, 2'b00};
        chk(spare_word == exp, "R8 spare form", spare_word, exp);
        for (int s = 0; s < 4; s++) begin
            logic [7:0] eb;
            eb = (s == 0) ? exp[23:16] : (s == 1) ? exp[15:8] : (s == 2) ? exp[7:0] : 8'h00;
            pk_sel = 2'(s);
            #1;
            chk(spare_byte == eb, "R9 byte order", spare_byte, eb);
        end
        pk_sel = 2'd0;
    endtask

    task automatic t_single_err();
        logic [21:0] good, bad, d;
        logic [7:0]  ln;
        logic [2:0]  cn;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 5);
        run_chunk("R11 clean", good);
        mem[8'hA7][5] = ~mem[8'hA7][5];
        run_chunk("R11 flipped", bad);
        d = good ^ bad;
        for (int k = 0; k < 8; k++) ln[k] = d[7+2*k];
        for (int j = 0; j < 3; j++) cn[j] = d[2*j+1];
        chk($countones(d) == 11, "R11 one bit per pair", $countones(d), 11);
        chk(ln == 8'hA7, "R11 byte index", ln, 8'hA7);
        chk(cn == 3'd5, "R11 bit position", cn, 5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired before all requirements were exercised");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_patterns();
        t_ignored();
        t_clear();
        t_dma();
        t_pack();
        t_single_err();
        t_pack();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule